// File: doc/BRIEF.md
# Two-Epoch Speculative Cache Line Controller

This block owns the tag and state array of a set-associative write-back data cache. It decides how each processor read or write moves a line between committed and speculative state. Every line carries a two-bit epoch tag. Two speculative epochs are live at any moment: the current one, which takes new writes, and the older one. When a commit retires the older epoch, the current epoch's writes are still held, so the rollback window never shrinks to nothing.

For each accepted access the block returns a one-cycle response:

- hit or miss;
- the way used, which is either the hit way or the chosen victim;
- whether a dirty line has to be written back;
- whether an epoch commit was started to serve the access;
- the epoch tag the line holds afterwards.

It counts the lines each epoch owns. It swaps the current and older identifiers when an epoch retires. It runs an internal tag walker that clears epoch bits on a commit or invalidates speculative lines on a rollback. While that walker runs, the request port is held not ready.

Top module: `sec_epoch_ctrl`

## Requirements
- R1: Epoch tag 2'b00 means committed. 2'b01 and 2'b10 are the two speculative identifiers. A line with a nonzero tag is always dirty. After reset the current identifier is 2'b01 and both line counts are zero.
- R2: A read hit leaves the line's tag unchanged, and the response reports that tag. A read miss fills a clean line with tag 00. resp_wb is 1 only if the evicted victim was valid and dirty.
- R3: A write miss fills the victim way with the current identifier, marks it dirty and adds one to the current epoch's count. resp_wb is 1 if the victim was valid and dirty.
- R4: A write hit on a committed line tags it with the current identifier and adds one to the count. resp_wb equals the line's previous dirty bit.
- R5: A write hit on a line of the current epoch gives resp_wb = 0, resp_commit = 0 and no count change.
- R6: A write hit on a line of the older epoch does the following:
  - it commits the older epoch;
  - the freed identifier becomes the current one;
  - it then writes the line with resp_wb = 1 and the new identifier;
  - it reports resp_commit = 1.
- R7: The current epoch's count reaches half of SETS*WAYS when a write increments it. That write reports resp_commit = 1, the older epoch is committed, and the identifiers swap.
- R8: The victim is the lowest-numbered invalid way. If there is none, it is the lowest-numbered committed way. If every way is speculative, the older epoch is committed first and the victim is then chosen from its lines.
- R9: The current epoch may own at most WAYS/2 ways of a set. A write that would add another first commits the older epoch and then proceeds under the swapped identifier.
- R10: A pulse on sys_req commits both epochs: all epoch bits clear, both counts become zero, and the current identifier is kept.
- R11: A pulse on rollback_req invalidates every speculative line and zeroes both counts. Committed lines stay valid.
- R12: Any walk holds req_ready low for exactly SETS*WAYS cycles. Priority is rollback_req, then sys_req, then an access. The response comes one cycle after acceptance, or one cycle after the walk if the access needed a commit.
- R13: When an epoch is committed, its line count is reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Access can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_set | input | SET_W | Set index |
| req_tag | input | TAG_W | Address tag |
| sys_req | input | 1 | I/O or system-call pulse: commit both epochs |
| rollback_req | input | 1 | Fault pulse: discard both epochs |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Access hit |
| resp_way | output | WAY_W | Hit way or victim way |
| resp_wb | output | 1 | Dirty line must be written back |
| resp_commit | output | 1 | A commit was started to serve this access |
| resp_epoch | output | 2 | Line's epoch tag after the access |
| cur_epoch | output | 2 | Current speculative identifier |
| cnt_cur | output | CNT_W | Lines owned by the current epoch |
| cnt_old | output | CNT_W | Lines owned by the older epoch |

## Verification
One directed stream fills a single set and exercises each kind of access:

- reads and writes that hit committed, current and older lines;
- write misses into a set whose per-set share is already full;
- a read miss into a set where every way is speculative.

These separate the four write cases and the three commit triggers that come from a lookup. A second stream spreads write misses over the other sets until the line count reaches its threshold. This shows that the threshold commit comes from the global count and not from the per-set cap. Pulses on sys_req and rollback_req are followed by accesses to lines that were speculative before the pulse. Their responses show whether the lines were committed, invalidated or left alone, and the walk length is measured from req_ready.

// File: rtl/sec_pkg.sv
package sec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WALK   = 2'd1,
    ST_REPLAY = 2'd2
  } ctl_state_e;

  localparam logic [1:0] EP_COMMITTED = 2'b00;
  localparam logic [1:0] EP_ID_A      = 2'b01;
  localparam logic [1:0] EP_ID_B      = 2'b10;
  localparam logic [1:0] EP_BOTH      = 2'b11;

  // The two speculative identifiers are one-hot, so the partner is the complement.
  function automatic logic [1:0] partner_id(input logic [1:0] id);
    return id ^ 2'b11;
  endfunction

  // A line is selected by a walk mask when its one-hot epoch bit is in the mask.
  function automatic logic ep_selected(input logic [1:0] ep, input logic [1:0] mask);
    return |(ep & mask);
  endfunction

endpackage

// File: rtl/sec_line_store.sv
module sec_line_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = $clog2(SETS * WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output logic [WAYS-1:0]   row_valid,
  output logic [WAYS-1:0]   row_dirty,
  output logic [1:0]        row_ep  [WAYS],
  output logic [TAG_W-1:0]  row_tag [WAYS],
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic              wr_dirty,
  input  logic [1:0]        wr_ep,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wk_en,
  input  logic [LINE_W-1:0] wk_idx,
  input  logic [1:0]        wk_mask,
  input  logic              wk_kill
);
  import sec_pkg::*;

  logic [WAYS-1:0]  v_q [SETS];
  logic [WAYS-1:0]  d_q [SETS];
  logic [1:0]       e_q [SETS][WAYS];
  logic [TAG_W-1:0] t_q [SETS][WAYS];

  logic [SET_W-1:0] wk_set;
  logic [WAY_W-1:0] wk_way;
  assign wk_set = wk_idx[LINE_W-1:WAY_W];
  assign wk_way = wk_idx[WAY_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0;
        d_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          e_q[s][w] <= EP_COMMITTED;
          t_q[s][w] <= '0;
        end
      end
    end else begin
      if (wr_en) begin
        v_q[wr_set][wr_way] <= 1'b1;
        d_q[wr_set][wr_way] <= wr_dirty;
        e_q[wr_set][wr_way] <= wr_ep;
        t_q[wr_set][wr_way] <= wr_tag;
      end
      if (wk_en && ep_selected(e_q[wk_set][wk_way], wk_mask)) begin
        e_q[wk_set][wk_way] <= EP_COMMITTED;
        if (wk_kill) begin
          v_q[wk_set][wk_way] <= 1'b0;
          d_q[wk_set][wk_way] <= 1'b0;
        end
      end
    end
  end

  assign row_valid = v_q[rd_set];
  assign row_dirty = d_q[rd_set];
  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign row_ep[w]  = e_q[rd_set][w];
    assign row_tag[w] = t_q[rd_set][w];
  end

endmodule

// File: rtl/sec_way_pick.sv
module sec_way_pick #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  row_valid,
  input  logic [WAYS-1:0]  row_dirty,
  input  logic [1:0]       row_ep  [WAYS],
  input  logic [TAG_W-1:0] row_tag [WAYS],
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [1:0]       cur_id,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [1:0]       hit_ep,
  output logic             hit_dirty,
  output logic             vic_ok,
  output logic [WAY_W-1:0] vic_way,
  output logic             vic_dirty,
  output logic [WAY_W:0]   cur_owned
);
  import sec_pkg::*;

  logic             inv_f, com_f;
  logic [WAY_W-1:0] inv_w, com_w;

  always_comb begin
    hit       = 1'b0;
    hit_way   = '0;
    inv_f     = 1'b0;
    inv_w     = '0;
    com_f     = 1'b0;
    com_w     = '0;
    cur_owned = '0;
    // Descending scan so the lowest-numbered way wins each search.
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (row_valid[w] && row_tag[w] == lk_tag) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!row_valid[w]) begin
        inv_f = 1'b1;
        inv_w = WAY_W'(w);
      end
      if (row_valid[w] && row_ep[w] == EP_COMMITTED) begin
        com_f = 1'b1;
        com_w = WAY_W'(w);
      end
      if (row_valid[w] && row_ep[w] == cur_id) cur_owned = cur_owned + 1'b1;
    end
  end

  assign hit_ep    = row_ep[hit_way];
  assign hit_dirty = row_dirty[hit_way];
  assign vic_ok    = inv_f | com_f;
  assign vic_way   = inv_f ? inv_w : com_w;
  assign vic_dirty = row_valid[vic_way] & row_dirty[vic_way];

endmodule

// File: rtl/sec_tag_walker.sv
module sec_tag_walker #(
  parameter int LINES = 16,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        start_mask,
  input  logic              start_kill,
  output logic              busy,
  output logic [LINE_W-1:0] idx,
  output logic [1:0]        mask,
  output logic              kill,
  output logic              last
);

  assign last = busy && (idx == LINE_W'(LINES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      mask <= '0;
      kill <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      mask <= start_mask;
      kill <= start_kill;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/sec_epoch_ctrl.sv
module sec_epoch_ctrl #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINES  = SETS * WAYS,
  localparam int LINE_W = $clog2(LINES),
  localparam int CNT_W  = $clog2(LINES + 1),
  localparam int HALF   = LINES / 2,
  localparam int CAP    = WAYS / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             sys_req,
  input  logic             rollback_req,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [WAY_W-1:0] resp_way,
  output logic             resp_wb,
  output logic             resp_commit,
  output logic [1:0]       resp_epoch,
  output logic [1:0]       cur_epoch,
  output logic [CNT_W-1:0] cnt_cur,
  output logic [CNT_W-1:0] cnt_old
);
  import sec_pkg::*;

  ctl_state_e       state_q;
  logic [1:0]       cur_q;
  logic [CNT_W-1:0] cnt_a_q, cnt_b_q;
  logic             pend_v_q, pend_wr_q, seen_q;
  logic [SET_W-1:0] pend_set_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic             resp_wr_q;

  // Request selection: a fresh request in idle, the parked one after a walk.
  logic             idle, idle_rb, idle_sys, act_fire, act_wr;
  logic [SET_W-1:0] act_set;
  logic [TAG_W-1:0] act_tag;

  assign idle      = (state_q == ST_IDLE);
  assign idle_rb   = idle && rollback_req;
  assign idle_sys  = idle && sys_req && !rollback_req;
  assign req_ready = idle && !rollback_req && !sys_req;
  assign act_fire  = (req_ready && req_valid) || (state_q == ST_REPLAY);
  assign act_wr    = idle ? req_write : pend_wr_q;
  assign act_set   = idle ? req_set   : pend_set_q;
  assign act_tag   = idle ? req_tag   : pend_tag_q;

  // Line store and way selection
  logic [WAYS-1:0]  row_valid, row_dirty;
  logic [1:0]       row_ep  [WAYS];
  logic [TAG_W-1:0] row_tag [WAYS];
  logic             hit, hit_dirty, vic_ok, vic_dirty;
  logic [WAY_W-1:0] hit_way, vic_way;
  logic [1:0]       hit_ep;
  logic [WAY_W:0]   cur_owned;

  // Named decision events (also observed by the checker)
  logic             need_commit, upd_en, upd_dirty, d_wb, d_inc, reach;
  logic [WAY_W-1:0] upd_way;
  logic [1:0]       upd_ep, older;
  logic             do_resp, start_older, wk_start;
  logic [1:0]       wk_start_mask;
  logic             wk_busy, wk_kill, wk_last;
  logic [LINE_W-1:0] wk_idx;
  logic [1:0]       wk_mask;
  logic [CNT_W-1:0] cur_cnt_now;

  sec_line_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_set(act_set),
    .row_valid(row_valid), .row_dirty(row_dirty), .row_ep(row_ep), .row_tag(row_tag),
    .wr_en(upd_en), .wr_set(act_set), .wr_way(upd_way), .wr_dirty(upd_dirty),
    .wr_ep(upd_ep), .wr_tag(act_tag),
    .wk_en(wk_busy), .wk_idx(wk_idx), .wk_mask(wk_mask), .wk_kill(wk_kill)
  );

  sec_way_pick #(.WAYS(WAYS), .TAG_W(TAG_W)) u_pick (
    .row_valid(row_valid), .row_dirty(row_dirty), .row_ep(row_ep), .row_tag(row_tag),
    .lk_tag(act_tag), .cur_id(cur_q),
    .hit(hit), .hit_way(hit_way), .hit_ep(hit_ep), .hit_dirty(hit_dirty),
    .vic_ok(vic_ok), .vic_way(vic_way), .vic_dirty(vic_dirty), .cur_owned(cur_owned)
  );

  assign older       = partner_id(cur_q);
  assign cur_cnt_now = (cur_q == EP_ID_A) ? cnt_a_q : cnt_b_q;

  always_comb begin
    need_commit = 1'b0;
    upd_en      = 1'b0;
    upd_way     = hit ? hit_way : vic_way;
    upd_dirty   = 1'b0;
    upd_ep      = EP_COMMITTED;
    d_wb        = 1'b0;
    d_inc       = 1'b0;
    if (act_fire) begin
      if (act_wr) begin
        if (hit && hit_ep == cur_q) begin
          upd_en    = 1'b1;
          upd_dirty = 1'b1;
          upd_ep    = cur_q;
        end else if ((hit && hit_ep != EP_COMMITTED) || cur_owned >= (WAY_W+1)'(CAP)
                     || (!hit && !vic_ok)) begin
          need_commit = 1'b1;
        end else begin
          upd_en    = 1'b1;
          upd_dirty = 1'b1;
          upd_ep    = cur_q;
          d_wb      = hit ? hit_dirty : vic_dirty;
          d_inc     = 1'b1;
        end
      end else if (!hit) begin
        if (!vic_ok) need_commit = 1'b1;
        else begin
          upd_en = 1'b1;
          d_wb   = vic_dirty;
        end
      end
    end
  end

  assign reach         = d_inc && (cur_cnt_now + 1'b1 == CNT_W'(HALF));
  assign do_resp       = act_fire && !need_commit;
  assign start_older   = act_fire && (need_commit || reach);
  assign wk_start      = start_older || idle_rb || idle_sys;
  assign wk_start_mask = start_older ? older : EP_BOTH;

  sec_tag_walker #(.LINES(LINES)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(wk_start), .start_mask(wk_start_mask),
    .start_kill(idle_rb), .busy(wk_busy), .idx(wk_idx), .mask(wk_mask),
    .kill(wk_kill), .last(wk_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_q      <= EP_ID_A;
      cnt_a_q    <= '0;
      cnt_b_q    <= '0;
      pend_v_q   <= 1'b0;
      pend_wr_q  <= 1'b0;
      pend_set_q <= '0;
      pend_tag_q <= '0;
      seen_q     <= 1'b0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      resp_wb    <= 1'b0;
      resp_commit <= 1'b0;
      resp_epoch <= EP_COMMITTED;
      resp_wr_q  <= 1'b0;
    end else begin
      if (wk_start)                         state_q <= ST_WALK;
      else if (state_q == ST_WALK && wk_last) state_q <= pend_v_q ? ST_REPLAY : ST_IDLE;
      else if (state_q == ST_REPLAY)        state_q <= ST_IDLE;

      if (act_fire && need_commit) begin
        pend_v_q   <= 1'b1;
        pend_wr_q  <= act_wr;
        pend_set_q <= act_set;
        pend_tag_q <= act_tag;
        seen_q     <= 1'b1;
      end else if (do_resp) begin
        pend_v_q <= 1'b0;
        seen_q   <= 1'b0;
      end

      resp_valid <= do_resp;
      if (do_resp) begin
        resp_hit    <= hit;
        resp_way    <= upd_way;
        resp_wb     <= d_wb;
        resp_commit <= seen_q | reach;
        resp_epoch  <= upd_en ? upd_ep : hit_ep;
        resp_wr_q   <= act_wr;
      end

      if (idle_rb || idle_sys) begin
        cnt_a_q <= '0;
        cnt_b_q <= '0;
      end else begin
        if (do_resp && d_inc) begin
          if (cur_q == EP_ID_A) cnt_a_q <= cnt_a_q + 1'b1;
          else                  cnt_b_q <= cnt_b_q + 1'b1;
        end
        if (start_older) begin
          cur_q <= older;
          if (older == EP_ID_A) cnt_a_q <= '0;
          else                  cnt_b_q <= '0;
        end
      end
    end
  end

  assign cur_epoch = cur_q;
  assign cnt_cur   = cur_cnt_now;
  assign cnt_old   = (cur_q == EP_ID_A) ? cnt_b_q : cnt_a_q;

endmodule

// File: rtl/sec_epoch_chk.sv
module sec_epoch_chk #(
  parameter int CNT_W = 5,
  parameter int HALF  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_en,
  input logic             upd_dirty,
  input logic [1:0]       upd_ep,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             resp_wr_q,
  input logic [1:0]       resp_epoch,
  input logic             wk_busy,
  input logic [1:0]       wk_mask,
  input logic             req_ready,
  input logic [1:0]       cur_q,
  input logic [CNT_W-1:0] cnt_cur,
  input logic [CNT_W-1:0] cnt_old
);

  AST_SPEC_IS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_ep != 2'b00) |-> upd_dirty); // R1

  AST_CUR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cur_q)); // R1

  AST_READ_MISS_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_wr_q && !resp_hit) |-> resp_epoch == 2'b00); // R2

  AST_ID_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wk_busy) && wk_mask != 2'b11) |-> cur_q == wk_mask); // R6

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_cur <= CNT_W'(HALF)) && (cnt_old <= CNT_W'(HALF))); // R7

  AST_STALL_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    wk_busy |-> !req_ready); // R12

endmodule

bind sec_epoch_ctrl sec_epoch_chk #(.CNT_W(CNT_W), .HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_dirty(upd_dirty), .upd_ep(upd_ep),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_wr_q(resp_wr_q),
  .resp_epoch(resp_epoch), .wk_busy(wk_busy), .wk_mask(wk_mask),
  .req_ready(req_ready), .cur_q(cur_q), .cnt_cur(cnt_cur), .cnt_old(cnt_old)
);

// File: tb/sec_epoch_ctrl_tb.sv
module sec_epoch_ctrl_tb;

  localparam int SETS = 4, WAYS = 4, TAG_W = 6;
  localparam int LINES = SETS * WAYS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, sys_req = 1'b0, rollback_req = 1'b0;
  logic [1:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic req_ready, resp_valid, resp_hit, resp_wb, resp_commit;
  logic [1:0] resp_way, resp_epoch, cur_epoch;
  logic [4:0] cnt_cur, cnt_old;

  always #10 clk = ~clk;

  sec_epoch_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_set(req_set), .req_tag(req_tag),
    .sys_req(sys_req), .rollback_req(rollback_req),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .resp_wb(resp_wb), .resp_commit(resp_commit), .resp_epoch(resp_epoch),
    .cur_epoch(cur_epoch), .cnt_cur(cnt_cur), .cnt_old(cnt_old)
  );

  typedef struct {
    logic [5:0] fields; // {hit, way[1:0], wb, commit, unused}
    logic [1:0] ep;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Monitor: samples a quarter period after the rising edge.
  initial forever begin
    @(posedge clk);
    #5;
    if (resp_valid) begin
      n_cmp++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected response: actual valid=1 expected none");
      end else begin
        exp_t e;
        logic [5:0] act;
        e = sb_q.pop_front();
        act = {resp_hit, resp_way, resp_wb, resp_commit, 1'b0};
        if (act != e.fields || resp_epoch != e.ep) begin
          n_bad++;
          $display("FAIL %s response: actual hit/way/wb/commit=%b ep=%b expected %b ep=%b",
                   e.req, act[5:1], resp_epoch, e.fields[5:1], e.ep);
        end
      end
    end
  end

  task automatic access(input bit wr, input int s, input int t, input bit h, input int w,
                        input bit wb, input bit cm, input logic [1:0] ep, input string rq);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.fields = {h, 2'(w), wb, cm, 1'b0};
    e.ep = ep;
    e.req = rq;
    sb_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_set = 2'(s); req_tag = TAG_W'(t);
    @(negedge clk);
    req_valid = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic check(input string rq, input int act, input int expv, input string what);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  task automatic status(input string rq, input int ce, input int cc, input int co);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    check(rq, cur_epoch, ce, "cur_epoch");
    check(rq, cnt_cur, cc, "cnt_cur");
    check(rq, cnt_old, co, "cnt_old");
  endtask

  task automatic pulse(input bit rb, input string rq);
    int n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (rb) rollback_req = 1'b1; else sys_req = 1'b1;
    @(negedge clk);
    rollback_req = 1'b0; sys_req = 1'b0;
    while (!req_ready) begin n++; @(negedge clk); end
    check(rq, n, LINES, "walk cycles with ready low");
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", req_ready, 1, "req_ready after reset");
    check("R1", resp_valid, 0, "resp_valid after reset");
    status("R1", 1, 0, 0);

    access(0, 0, 1, 0, 0, 0, 0, 2'b00, "R2");   // read miss fills committed
    access(0, 0, 1, 1, 0, 0, 0, 2'b00, "R2");   // read hit keeps tag
    access(1, 0, 1, 1, 0, 0, 0, 2'b01, "R4");   // write hit committed clean
    access(1, 0, 1, 1, 0, 0, 0, 2'b01, "R5");   // write hit current
    status("R5", 1, 1, 0);
    access(1, 0, 2, 0, 1, 0, 0, 2'b01, "R3");   // write miss
    status("R3", 1, 2, 0);
    access(1, 0, 3, 0, 2, 0, 1, 2'b10, "R9");   // per-set share full
    status("R13", 2, 1, 2);
    access(1, 0, 1, 1, 0, 1, 1, 2'b01, "R6");   // hit on older epoch
    status("R6", 1, 1, 1);
    access(0, 0, 2, 1, 1, 0, 0, 2'b00, "R2");   // line committed by walk
    access(0, 0, 4, 0, 3, 0, 0, 2'b00, "R8");   // invalid way first
    access(0, 0, 5, 0, 1, 1, 0, 2'b00, "R8");   // lowest committed, dirty victim
    access(1, 0, 5, 1, 1, 0, 0, 2'b01, "R4");
    access(1, 0, 4, 1, 3, 0, 1, 2'b10, "R9");
    access(1, 0, 3, 1, 2, 1, 0, 2'b10, "R4");   // committed dirty hit
    access(0, 0, 6, 0, 0, 1, 1, 2'b00, "R8");   // every way speculative
    status("R8", 1, 0, 2);
    access(1, 0, 6, 1, 0, 0, 0, 2'b01, "R4");
    access(1, 0, 5, 1, 1, 1, 0, 2'b01, "R4");
    for (int s = 1; s < 4; s++) begin
      access(1, s, 1, 0, 0, 0, 0, 2'b01, "R3");
      access(1, s, 2, 0, 1, 0, (s == 3), 2'b01, "R7");
    end
    status("R7", 2, 0, 8);
    pulse(0, "R12");
    status("R10", 2, 0, 0);
    access(1, 0, 6, 1, 0, 1, 0, 2'b10, "R10");  // former speculative line now committed
    pulse(1, "R12");
    status("R11", 2, 0, 0);
    access(0, 0, 6, 0, 0, 0, 0, 2'b00, "R11");  // speculative line invalidated
    access(0, 1, 1, 1, 0, 0, 0, 2'b00, "R11");  // committed line survives
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule